// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings the DDR2 devices behind a memory controller out of power-up without software help. A start pulse launches the sequence. The block first waits a stabilization interval, which is nominally 200 µs and is given to it as a count of memory-clock cycles. It then issues the device bring-up commands to chip 0 and repeats them for each further chip. Between these steps come the precharge, the two auto-refreshes, the mode-register loads that reset the DLL and then make it active, and the load and release of the OCD default. After the last chip it switches its status to ready. That flag gates system-bus accesses, so no master can reach memory before the devices are usable.

Each command is presented for one cycle on a command bus. The bus carries a chip index, a two-bit command kind, a two-bit mode-register select and an address value. The same command is also decoded to active-low row-strobe, column-strobe and write-enable levels. All wait lengths are inputs, counted in memory-clock cycles. Consecutive commands are never closer than the mode-register gap, and precharge and refresh also respect their own recovery times.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, status_o is 00, ready_o is 0 and cmd_valid_o is 0. The bus also idles as a NOP: type 11, bank 0, address 0, chip 0, all three strobe pins high.
- R2: cmd_type_o encodes precharge-all as 00, auto-refresh as 01, mode-register load as 10 and NOP as 11. On a mode-register load, cmd_bank_o picks MR as 00, EMR1 as 01, EMR2 as 10 and EMR3 as 11. The pins {ras_n_o,cas_n_o,we_n_o} read 111 for NOP, 010 for precharge-all, 001 for auto-refresh and 000 for a mode-register load. Whenever cmd_valid_o is low, the bus shows the NOP idle values.
- R3: The first command strobe comes stab_cycles_i cycles after the clock edge that samples start_i. A value of 0 is taken as 1.
- R4: Each chip receives these 12 commands in this order: NOP; precharge-all; EMR2←0; EMR3←0; EMR1←0; MR←0x132; precharge-all; auto-refresh; auto-refresh; MR←0x032; EMR1←0x380; EMR1←0.
- R5: The spacing in cycles from one strobe to the next is the larger of tmrd_i and a step-specific wait. That wait is nop_wait_i after the NOP, trp_i after a precharge-all, trfc_i after an auto-refresh and dll_wait_i after MR←0x032. After any other command it is 0. A spacing of 0 is taken as 1.
- R6: Chips 0 through num_chips_m1_i are served in ascending order with the same 12 commands. Only cmd_chip_o differs between them, and each chip's NOP follows the previous chip's last command by the R5 spacing.
- R7: status_o becomes 01 and ready_o 1 exactly max(tmrd_i,1) cycles after the final command strobe. Both then hold, with no strobes, until a new start is accepted.
- R8: A start pulse that arrives while a sequence is running is ignored. It changes neither the command list nor its timing.
- R9: A start accepted from ready returns status_o to 00 and ready_o to 0 in the cycle after the sampling edge, and then reruns the whole sequence.
- R10: Each command shows cmd_valid_o for exactly one cycle. With every wait at 0, the commands come on consecutive cycles and none is merged or dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| num_chips_m1_i | input | CHIP_W | Number of chips minus one |
| stab_cycles_i | input | WAIT_W | Power-up stabilization wait |
| nop_wait_i | input | WAIT_W | Wait after the NOP (nominally 400 ns) |
| dll_wait_i | input | WAIT_W | Wait after the DLL-active MR load (nominally 200) |
| tmrd_i | input | WAIT_W | Minimum gap between commands |
| trp_i | input | WAIT_W | Wait after precharge-all |
| trfc_i | input | WAIT_W | Wait after auto-refresh |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_chip_o | output | CHIP_W | Target chip index |
| cmd_type_o | output | 2 | Command kind |
| cmd_bank_o | output | 2 | Mode-register select |
| cmd_addr_o | output | ADDR_W | Mode-register value |
| ras_n_o | output | 1 | Row strobe level, active low |
| cas_n_o | output | 1 | Column strobe level, active low |
| we_n_o | output | 1 | Write enable level, active low |
| status_o | output | 2 | 00 initializing, 01 ready |
| ready_o | output | 1 | High once memory may be accessed |

## Verification
The bench targets the spacing rule with waits both below and above tmrd_i. A design that added the waits instead of taking the maximum, or that ignored tmrd_i after a refresh, would move every later strobe. Zero-valued waits must produce back-to-back strobes, and a timer that did not clamp zero would hang or skip a command. The bench sends a stray start in the middle of a run, which a careless design would use to restart at chip 0. It also starts again from ready, which a design that latched ready permanently would refuse. Finally it checks that the chip index rolls through four chips and that a reset taken mid-run drops the bus straight back to NOP.

// File: rtl/ddr2_pwrup_pkg.sv
package ddr2_pwrup_pkg;

  typedef enum logic [1:0] {
    CMD_PREA = 2'b00,
    CMD_REF  = 2'b01,
    CMD_MRS  = 2'b10,
    CMD_NOP  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    MSEL_MR   = 2'b00,
    MSEL_EMR1 = 2'b01,
    MSEL_EMR2 = 2'b10,
    MSEL_EMR3 = 2'b11
  } msel_e;

  typedef enum logic [2:0] {
    GAP_MRD,
    GAP_NOP,
    GAP_RP,
    GAP_RFC,
    GAP_DLL
  } gap_e;

  typedef enum logic [1:0] {
    STAT_INIT  = 2'b00,
    STAT_READY = 2'b01
  } stat_e;

  localparam int STEPS_PER_CHIP = 12;

endpackage

// File: rtl/pwrup_step_rom.sv
module pwrup_step_rom
  import ddr2_pwrup_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int STEP_W = 4
) (
  input  logic [STEP_W-1:0] step_i,
  output cmd_e              kind_o,
  output msel_e             bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output gap_e              gap_o,
  output logic              last_o
);

  always_comb begin
    kind_o = CMD_MRS;
    bank_o = MSEL_MR;
    addr_o = '0;
    gap_o  = GAP_MRD;
    case (step_i)
      4'd0:  begin kind_o = CMD_NOP;  gap_o = GAP_NOP; end
      4'd1:  begin kind_o = CMD_PREA; gap_o = GAP_RP;  end
      4'd2:  bank_o = MSEL_EMR2;
      4'd3:  bank_o = MSEL_EMR3;
      4'd4:  bank_o = MSEL_EMR1;
      4'd5:  addr_o = ADDR_W'(12'h132);
      4'd6:  begin kind_o = CMD_PREA; gap_o = GAP_RP;  end
      4'd7:  begin kind_o = CMD_REF;  gap_o = GAP_RFC; end
      4'd8:  begin kind_o = CMD_REF;  gap_o = GAP_RFC; end
      4'd9:  begin addr_o = ADDR_W'(12'h032); gap_o = GAP_DLL; end
      4'd10: begin bank_o = MSEL_EMR1; addr_o = ADDR_W'(12'h380); end
      default: bank_o = MSEL_EMR1;
    endcase
  end

  assign last_o = (step_i == STEP_W'(STEPS_PER_CHIP - 1));

endmodule

// File: rtl/pwrup_pin_decode.sv
module pwrup_pin_decode
  import ddr2_pwrup_pkg::*;
(
  input  cmd_e kind_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);

  always_comb begin
    case (kind_i)
      CMD_PREA: {ras_n_o, cas_n_o, we_n_o} = 3'b010;
      CMD_REF:  {ras_n_o, cas_n_o, we_n_o} = 3'b001;
      CMD_MRS:  {ras_n_o, cas_n_o, we_n_o} = 3'b000;
      default:  {ras_n_o, cas_n_o, we_n_o} = 3'b111;
    endcase
  end

endmodule

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
  parameter int WAIT_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] val_i,
  output logic              expire_o
);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (val_i == '0) ? WAIT_W'(1) : val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - WAIT_W'(1);
    end
  end

  assign expire_o = (cnt_q == WAIT_W'(1));

  // R5: between loads the count falls by exactly one per cycle
  p_timer_count_r5: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q > WAIT_W'(1)) |=> (cnt_q == $past(cnt_q) - WAIT_W'(1)));

  // R10: a zero wait still yields a nonzero count, so no command is skipped
  p_timer_load_r10: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q != '0));

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
  import ddr2_pwrup_pkg::*;
#(
  parameter int CHIP_W = 2,
  parameter int WAIT_W = 18,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CHIP_W-1:0] num_chips_m1_i,
  input  logic [WAIT_W-1:0] stab_cycles_i,
  input  logic [WAIT_W-1:0] nop_wait_i,
  input  logic [WAIT_W-1:0] dll_wait_i,
  input  logic [WAIT_W-1:0] tmrd_i,
  input  logic [WAIT_W-1:0] trp_i,
  input  logic [WAIT_W-1:0] trfc_i,
  output logic              cmd_valid_o,
  output logic [CHIP_W-1:0] cmd_chip_o,
  output logic [1:0]        cmd_type_o,
  output logic [1:0]        cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        status_o,
  output logic              ready_o
);

  localparam int STEP_W = $clog2(STEPS_PER_CHIP);

  typedef enum logic [1:0] {FS_IDLE, FS_RUN, FS_FINISH} fsm_e;

  fsm_e              fsm_q;
  logic [STEP_W-1:0] step_q;
  logic [CHIP_W-1:0] chip_q;
  stat_e             status_q;

  cmd_e              rom_kind;
  msel_e             rom_bank;
  logic [ADDR_W-1:0] rom_addr;
  gap_e              rom_gap;
  logic              rom_last;
  logic              dec_ras_n, dec_cas_n, dec_we_n;

  logic              expire;
  logic              start_ok;
  logic              tmr_load;
  logic [WAIT_W-1:0] extra_wait;
  logic [WAIT_W-1:0] gap_val;
  logic [WAIT_W-1:0] tmr_val;

  pwrup_step_rom #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_rom (
    .step_i (step_q),
    .kind_o (rom_kind),
    .bank_o (rom_bank),
    .addr_o (rom_addr),
    .gap_o  (rom_gap),
    .last_o (rom_last)
  );

  pwrup_pin_decode u_pins (
    .kind_i  (rom_kind),
    .ras_n_o (dec_ras_n),
    .cas_n_o (dec_cas_n),
    .we_n_o  (dec_we_n)
  );

  always_comb begin
    case (rom_gap)
      GAP_NOP: extra_wait = nop_wait_i;
      GAP_RP:  extra_wait = trp_i;
      GAP_RFC: extra_wait = trfc_i;
      GAP_DLL: extra_wait = dll_wait_i;
      default: extra_wait = '0;
    endcase
  end

  assign gap_val  = (extra_wait > tmrd_i) ? extra_wait : tmrd_i;
  assign start_ok = start_i && (fsm_q == FS_IDLE);
  assign tmr_load = start_ok || ((fsm_q == FS_RUN) && expire);
  assign tmr_val  = start_ok ? stab_cycles_i
                  : (rom_last && chip_q == num_chips_m1_i) ? tmrd_i : gap_val;

  pwrup_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expire_o (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q       <= FS_IDLE;
      step_q      <= '0;
      chip_q      <= '0;
      status_q    <= STAT_INIT;
      cmd_valid_o <= 1'b0;
      cmd_chip_o  <= '0;
      cmd_type_o  <= CMD_NOP;
      cmd_bank_o  <= '0;
      cmd_addr_o  <= '0;
      ras_n_o     <= 1'b1;
      cas_n_o     <= 1'b1;
      we_n_o      <= 1'b1;
    end else begin
      cmd_valid_o <= 1'b0;
      cmd_chip_o  <= '0;
      cmd_type_o  <= CMD_NOP;
      cmd_bank_o  <= '0;
      cmd_addr_o  <= '0;
      ras_n_o     <= 1'b1;
      cas_n_o     <= 1'b1;
      we_n_o      <= 1'b1;
      case (fsm_q)
        FS_IDLE: begin
          if (start_i) begin
            fsm_q    <= FS_RUN;
            step_q   <= '0;
            chip_q   <= '0;
            status_q <= STAT_INIT;
          end
        end
        FS_RUN: begin
          if (expire) begin
            cmd_valid_o <= 1'b1;
            cmd_chip_o  <= chip_q;
            cmd_type_o  <= rom_kind;
            cmd_bank_o  <= rom_bank;
            cmd_addr_o  <= rom_addr;
            ras_n_o     <= dec_ras_n;
            cas_n_o     <= dec_cas_n;
            we_n_o      <= dec_we_n;
            if (rom_last) begin
              step_q <= '0;
              if (chip_q == num_chips_m1_i) begin
                fsm_q <= FS_FINISH;
              end else begin
                chip_q <= chip_q + CHIP_W'(1);
              end
            end else begin
              step_q <= step_q + STEP_W'(1);
            end
          end
        end
        FS_FINISH: begin
          if (expire) begin
            status_q <= STAT_READY;
            fsm_q    <= FS_IDLE;
          end
        end
        default: fsm_q <= FS_IDLE;
      endcase
    end
  end

  assign status_o = status_q;
  assign ready_o  = (status_q == STAT_READY);

  // R2: an idle bus always shows the NOP encoding
  p_idle_bus_nop_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid_o |-> (cmd_type_o == 2'b11 && ras_n_o && cas_n_o && we_n_o));

  // R2: a mode-register load drives all three strobes low
  p_mrs_pins_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && cmd_type_o == 2'b10) |-> (!ras_n_o && !cas_n_o && !we_n_o));

  // R2: a precharge-all drives 010
  p_prea_pins_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && cmd_type_o == 2'b00) |-> (!ras_n_o && cas_n_o && !we_n_o));

  // R7: no command goes out once ready
  p_no_cmd_when_ready_r7: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> !cmd_valid_o);

  // R7: ready holds until a new start
  p_ready_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !start_i) |=> ready_o);

  // R8: a start during a run leaves the position unchanged
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == FS_RUN && start_i && !expire) |=>
      (step_q == $past(step_q) && chip_q == $past(chip_q) && fsm_q == FS_RUN));

endmodule

// File: tb/ddr2_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module ddr2_pwrup_seq_tb_top;

  localparam int CHIP_W = 2;
  localparam int WAIT_W = 18;
  localparam int ADDR_W = 14;
  localparam int LOG_N  = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [CHIP_W-1:0] num_chips_m1_i = '0;
  logic [WAIT_W-1:0] stab_cycles_i = '0, nop_wait_i = '0, dll_wait_i = '0;
  logic [WAIT_W-1:0] tmrd_i = '0, trp_i = '0, trfc_i = '0;
  logic              cmd_valid_o;
  logic [CHIP_W-1:0] cmd_chip_o;
  logic [1:0]        cmd_type_o, cmd_bank_o, status_o;
  logic [ADDR_W-1:0] cmd_addr_o;
  logic              ras_n_o, cas_n_o, we_n_o, ready_o;

  always #2.5 clk = ~clk;

  ddr2_pwrup_seq #(.CHIP_W(CHIP_W), .WAIT_W(WAIT_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .num_chips_m1_i(num_chips_m1_i),
    .stab_cycles_i(stab_cycles_i), .nop_wait_i(nop_wait_i), .dll_wait_i(dll_wait_i),
    .tmrd_i(tmrd_i), .trp_i(trp_i), .trfc_i(trfc_i),
    .cmd_valid_o(cmd_valid_o), .cmd_chip_o(cmd_chip_o), .cmd_type_o(cmd_type_o),
    .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o), .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o), .we_n_o(we_n_o), .status_o(status_o), .ready_o(ready_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  int lg_type [LOG_N];
  int lg_bank [LOG_N];
  int lg_addr [LOG_N];
  int lg_chip [LOG_N];
  int lg_pins [LOG_N];
  int lg_cyc  [LOG_N];
  int log_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && cmd_valid_o && log_n < LOG_N) begin
      lg_type[log_n] = cmd_type_o;
      lg_bank[log_n] = cmd_bank_o;
      lg_addr[log_n] = cmd_addr_o;
      lg_chip[log_n] = cmd_chip_o;
      lg_pins[log_n] = {ras_n_o, cas_n_o, we_n_o};
      lg_cyc[log_n]  = cyc;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_type(input int s);
    case (s)
      0: return 3;
      1, 6: return 0;
      7, 8: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int exp_bank(input int s);
    case (s)
      2: return 2;
      3: return 3;
      4, 10, 11: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_addr(input int s);
    case (s)
      5: return 'h132;
      9: return 'h032;
      10: return 'h380;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_pins(input int t);
    case (t)
      0: return 3'b010;
      1: return 3'b001;
      2: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic int exp_gap(input int s);
    int extra;
    int g;
    case (s)
      0: extra = int'(nop_wait_i);
      1, 6: extra = int'(trp_i);
      7, 8: extra = int'(trfc_i);
      9: extra = int'(dll_wait_i);
      default: extra = 0;
    endcase
    g = (extra > int'(tmrd_i)) ? extra : int'(tmrd_i);
    return (g == 0) ? 1 : g;
  endfunction

  task automatic check_idle_bus(input string req);
    chk(status_o == 2'b00, req, status_o, 0);
    chk(ready_o == 1'b0, req, ready_o, 0);
    chk(cmd_valid_o == 1'b0, req, cmd_valid_o, 0);
    chk(cmd_type_o == 2'b11, req, cmd_type_o, 3);
    chk({ras_n_o, cas_n_o, we_n_o} == 3'b111, req, {ras_n_o, cas_n_o, we_n_o}, 7);
    chk(cmd_bank_o == 0 && cmd_addr_o == 0 && cmd_chip_o == 0, req,
        cmd_addr_o, 0);
  endtask

  // Runs one full sequence and checks every command and the ready point
  task automatic run_seq(input int chips_m1, input bit stray_start);
    int start_edge;
    int n_exp;
    int t_exp;
    int guard;
    int last_cyc;
    int base;
    num_chips_m1_i = CHIP_W'(chips_m1);
    @(negedge clk);
    log_n = 0;
    start_i = 1'b1;
    start_edge = cyc + 1;
    @(negedge clk);
    start_i = 1'b0;
    // R9: status falls back to initializing right after the sampling edge
    chk(status_o == 2'b00 && ready_o == 1'b0, "R9", status_o, 0);
    if (stray_start) begin
      guard = 0;
      while (log_n < 5 && guard < 5000) begin @(negedge clk); guard++; end
      start_i = 1'b1;  // R8: stray pulse while running
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (!ready_o && guard < 5000) begin @(negedge clk); guard++; end
    n_exp = (chips_m1 + 1) * 12;
    chk(log_n == n_exp, "R6", log_n, n_exp);
    t_exp = start_edge + ((stab_cycles_i == 0) ? 1 : int'(stab_cycles_i));
    for (int i = 0; i < n_exp && i < log_n; i++) begin
      int s;
      s = i % 12;
      chk(lg_type[i] == exp_type(s), "R4", lg_type[i], exp_type(s));
      chk(lg_bank[i] == exp_bank(s), "R2", lg_bank[i], exp_bank(s));
      chk(lg_addr[i] == exp_addr(s), "R4", lg_addr[i], exp_addr(s));
      chk(lg_chip[i] == i / 12, "R6", lg_chip[i], i / 12);
      chk(lg_pins[i] == exp_pins(exp_type(s)), "R2", lg_pins[i], exp_pins(exp_type(s)));
      chk(lg_cyc[i] == t_exp, (i == 0) ? "R3" : "R5", lg_cyc[i], t_exp);
      t_exp = t_exp + exp_gap(s);
    end
    base = (log_n > 0) ? log_n - 1 : 0;
    last_cyc = lg_cyc[base] + ((tmrd_i == 0) ? 1 : int'(tmrd_i));
    chk(cyc == last_cyc, "R7", cyc, last_cyc);
    chk(status_o == 2'b01, "R7", status_o, 1);
    repeat (15) @(negedge clk);
    chk(log_n == n_exp && ready_o == 1'b1, "R7", log_n, n_exp);
  endtask

  task automatic t_reset_state;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_idle_bus("R1");
    rst = 1'b0;
    @(negedge clk);
    check_idle_bus("R1");
  endtask

  task automatic t_single_chip;
    stab_cycles_i = 5; nop_wait_i = 4; tmrd_i = 2;
    trp_i = 3; trfc_i = 6; dll_wait_i = 10;
    run_seq(0, 1'b0);
  endtask

  task automatic t_two_chips_stray_start;
    stab_cycles_i = 0; nop_wait_i = 0; tmrd_i = 3;
    trp_i = 1; trfc_i = 7; dll_wait_i = 2;
    run_seq(1, 1'b1);
  endtask

  task automatic t_four_chips_zero_waits;
    stab_cycles_i = 0; nop_wait_i = 0; tmrd_i = 0;
    trp_i = 0; trfc_i = 0; dll_wait_i = 0;
    run_seq(3, 1'b0);
    // R10: with zero waits every strobe is one cycle after the previous one
    for (int i = 1; i < log_n; i++)
      chk(lg_cyc[i] == lg_cyc[i-1] + 1, "R10", lg_cyc[i], lg_cyc[i-1] + 1);
  endtask

  task automatic t_reset_midrun;
    stab_cycles_i = 2; tmrd_i = 2; nop_wait_i = 3;
    @(negedge clk);
    log_n = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_idle_bus("R1");
    rst = 1'b0;
    @(negedge clk);
    check_idle_bus("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_single_chip();
    t_two_chips_stray_start();
    t_four_chips_zero_waits();
    t_reset_midrun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule